// File: doc/BRIEF.md
# Variable-Width CRC-4 Command Checker

This block computes and verifies the 4-bit checksum that guards read and write transactions exchanged with a contactless memory card. Cards come in three sizes, and the card type code picks the address width. A start strobe captures a command bit, an address, a data byte and a 12-bit response word. The block then packs the command bit, address and data into one message whose length depends on the card type. It runs a 4-bit CRC over that message one bit per clock and compares the result with the checksum nibble carried in the response.

For writes, the same CRC goes into an assembled outgoing frame word of the correct length. Writes to the protected low addresses are refused before any CRC work starts. An unrecognised card type code raises an error instead of producing a result. All status outputs hold their value until the next accepted start.

Top module: `crc4c_checker`

## Requirements
- R1: After reset, done, match, error, refused and busy are 0 and crc_out is 0x5.
- R2: Card code 0x0D selects a 5-bit address, 0x1D selects 8 bits and 0x3D selects 10 bits. The message is address width + 9 bits long (14, 17 or 19). With start sampled at clock edge 0, busy is 1 after edges 0 to L-1, and done rises after edge L, where L is the message length.
- R3: The message equals data << (aw+1) | addr << 1 | cmd_rd, where aw is the address width. cmd_rd is 1 for a read and 0 for a write. Address bits at or above aw are ignored.
- R4: The CRC starts at 0x5 and takes the message least significant bit first. For each bit, fb = crc[0] xor bit, then crc is shifted right by one, then crc is XORed with 0xC when fb is 1. No final XOR is applied. crc_out holds the final value while done is 1.
- R5: match equals done AND (crc_out == rsp[11:8]). rsp[7:0] has no effect.
- R6: A start with any other card code sets error after edge 0. done and match stay 0 and busy stays 0.
- R7: A write (cmd_rd = 0) whose masked address is 0 to 4 sets refused after edge 0. done and busy stay 0. Reads of those addresses, and writes to address 5 and above, run normally.
- R8: While done is 1, frame = crc_out << (aw+9) | data << (aw+1) | addr << 1 | cmd_rd, and frame_len = aw + 13.
- R9: A start strobe while busy is 1 is ignored, including its operands and response word.
- R10: An accepted start clears done, match, error and refused from the previous operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| card_type | input | 8 | Card type code |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| addr | input | 10 | Byte address, upper bits masked per card type |
| data | input | 8 | Data byte |
| rsp | input | 12 | Response word, checksum in bits 11:8 |
| crc_out | output | 4 | Computed CRC |
| match | output | 1 | Computed CRC equals the received nibble |
| done | output | 1 | CRC finished for the last operation |
| error | output | 1 | Last start had an unknown card code |
| refused | output | 1 | Last start was a write to a protected address |
| busy | output | 1 | CRC in progress |
| frame | output | 23 | Assembled frame word {crc, data, addr, cmd} |
| frame_len | output | 5 | Number of valid frame bits |

## Verification
A wrong address width selection changes the message length, so it shows up as done rising one or more cycles early or late. It also changes crc_out and frame_len on the same cycle. A misplaced field or a wrong feedback step leaves the latency correct but corrupts crc_out and frame. This shows on the first cycle that done is high, and the match flag then disagrees with the planted good or bad nibble. Leaked upper address bits or an ignored-start path that latches new operands show the same way: a CRC that differs from the one expected for the masked, originally captured operands.

// File: rtl/crc4c_pkg.sv
package crc4c_pkg;
   localparam int DATA_W     = 8;
   localparam int ADDR_W_MAX = 10;
   localparam int CRC_W      = 4;
   localparam int NUM_KINDS  = 3;
   localparam int MSG_W      = DATA_W + ADDR_W_MAX + 1;
   localparam int LEN_W      = $clog2(MSG_W + 1);
   localparam int FRAME_W    = CRC_W + MSG_W;
   localparam int FLEN_W     = $clog2(FRAME_W + 1);
   localparam int AW_W       = $clog2(ADDR_W_MAX + 1);

   localparam logic [7:0] KIND_CODE [NUM_KINDS] = '{8'h0D, 8'h1D, 8'h3D};
   localparam int         KIND_AW   [NUM_KINDS] = '{5, 8, 10};

   typedef struct packed {
      logic            ok;
      logic [AW_W-1:0] aw;
   } kind_t;
endpackage

// File: rtl/crc4c_kind_dec.sv
module crc4c_kind_dec
   import crc4c_pkg::*;
(
   input  logic [7:0] code,
   output kind_t      kind
);
   logic [NUM_KINDS-1:0] hit;

   generate
      for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
         assign hit[k] = (code == KIND_CODE[k]);
      end
   endgenerate

   always_comb begin
      kind = '0;
      for (int k = 0; k < NUM_KINDS; k++) begin
         if (hit[k]) begin
            kind.ok = 1'b1;
            kind.aw = AW_W'(KIND_AW[k]);
         end
      end
   end
endmodule

// File: rtl/crc4c_msg_pack.sv
module crc4c_msg_pack
   import crc4c_pkg::*;
(
   input  logic [AW_W-1:0]       aw,
   input  logic                  cmd,
   input  logic [ADDR_W_MAX-1:0] addr,
   input  logic [DATA_W-1:0]     data,
   output logic [ADDR_W_MAX-1:0] addr_m,
   output logic [MSG_W-1:0]      msg,
   output logic [LEN_W-1:0]      len
);
   logic [ADDR_W_MAX-1:0] amask;
   logic [LEN_W-1:0]      dsh;

   always_comb begin
      amask  = ~({ADDR_W_MAX{1'b1}} << aw);
      addr_m = addr & amask;
      dsh    = LEN_W'(aw) + LEN_W'(1);
      msg    = (MSG_W'(data) << dsh) | (MSG_W'(addr_m) << 1) | MSG_W'(cmd);
      len    = LEN_W'(aw) + LEN_W'(DATA_W + 1);
   end
endmodule

// File: rtl/crc4c_serial.sv
module crc4c_serial
   import crc4c_pkg::*;
#(
   parameter logic [CRC_W-1:0] POLY    = 4'hC,
   parameter logic [CRC_W-1:0] INIT    = 4'h5,
   parameter bit               REFLECT = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [MSG_W-1:0] msg,
   input  logic [LEN_W-1:0] len,
   output logic [CRC_W-1:0] crc,
   output logic             busy,
   output logic             last_bit
);
   logic [MSG_W-1:0] sh_q;
   logic [LEN_W-1:0] rem_q;
   logic [CRC_W-1:0] nxt;

   generate
      if (REFLECT) begin : g_right
         always_comb begin
            nxt = crc >> 1;
            if (crc[0] ^ sh_q[0]) nxt = nxt ^ POLY;
         end
      end else begin : g_left
         always_comb begin
            nxt = crc << 1;
            if (crc[CRC_W-1] ^ sh_q[0]) nxt = nxt ^ POLY;
         end
      end
   endgenerate

   assign last_bit = busy && (rem_q == LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc   <= INIT;
         sh_q  <= '0;
         rem_q <= '0;
         busy  <= 1'b0;
      end else if (load) begin
         crc   <= INIT;
         sh_q  <= msg;
         rem_q <= len;
         busy  <= (len != '0);
      end else if (busy) begin
         crc   <= nxt;
         sh_q  <= sh_q >> 1;
         rem_q <= rem_q - LEN_W'(1);
         if (last_bit) busy <= 1'b0;
      end
   end

   // R2
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rem_q != '0));
   // R2
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && !load) |=> !busy);
   // R4
   crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load) |=> $stable(crc));
endmodule

// File: rtl/crc4c_frame_build.sv
module crc4c_frame_build
   import crc4c_pkg::*;
(
   input  logic [AW_W-1:0]       aw,
   input  logic                  cmd,
   input  logic [ADDR_W_MAX-1:0] addr_m,
   input  logic [DATA_W-1:0]     data,
   input  logic [CRC_W-1:0]      crc,
   output logic [FRAME_W-1:0]    frame,
   output logic [FLEN_W-1:0]     frame_len
);
   logic [FLEN_W-1:0] dsh;
   logic [FLEN_W-1:0] csh;

   always_comb begin
      dsh       = FLEN_W'(aw) + FLEN_W'(1);
      csh       = FLEN_W'(aw) + FLEN_W'(DATA_W + 1);
      frame     = (FRAME_W'(crc) << csh) | (FRAME_W'(data) << dsh)
                | (FRAME_W'(addr_m) << 1) | FRAME_W'(cmd);
      frame_len = FLEN_W'(aw) + FLEN_W'(DATA_W + 1 + CRC_W);
   end
endmodule

// File: rtl/crc4c_checker.sv
module crc4c_checker
   import crc4c_pkg::*;
#(
   parameter logic [CRC_W-1:0] CRC_POLY  = 4'hC,
   parameter logic [CRC_W-1:0] CRC_INIT  = 4'h5,
   parameter bit               REFLECT   = 1'b1,
   parameter int               PROT_LAST = 4,
   parameter int               RSP_W     = 12,
   parameter int               CHK_LSB   = 8
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [7:0]            card_type,
   input  logic                  cmd_rd,
   input  logic [ADDR_W_MAX-1:0] addr,
   input  logic [DATA_W-1:0]     data,
   input  logic [RSP_W-1:0]      rsp,
   output logic [CRC_W-1:0]      crc_out,
   output logic                  match,
   output logic                  done,
   output logic                  error,
   output logic                  refused,
   output logic                  busy,
   output logic [FRAME_W-1:0]    frame,
   output logic [FLEN_W-1:0]     frame_len
);
   generate
      if (CHK_LSB + CRC_W > RSP_W) begin : g_bad_rsp
         $error("checksum field lies outside the response word");
      end
      if (PROT_LAST >= (1 << ADDR_W_MAX)) begin : g_bad_prot
         $error("protected range exceeds the address space");
      end
   endgenerate

   kind_t                 kind;
   logic [ADDR_W_MAX-1:0] addr_m;
   logic [MSG_W-1:0]      msg;
   logic [LEN_W-1:0]      len;
   logic                  accept, prot, load, last_bit;

   logic [AW_W-1:0]       aw_q;
   logic                  cmd_q;
   logic [ADDR_W_MAX-1:0] addr_q;
   logic [DATA_W-1:0]     data_q;
   logic [CRC_W-1:0]      rx_q;

   crc4c_kind_dec u_dec (.code(card_type), .kind(kind));

   crc4c_msg_pack u_pack (
      .aw(kind.aw), .cmd(cmd_rd), .addr(addr), .data(data),
      .addr_m(addr_m), .msg(msg), .len(len));

   assign accept = start && !busy;
   assign prot   = !cmd_rd && (int'(addr_m) <= PROT_LAST);
   assign load   = accept && kind.ok && !prot;

   crc4c_serial #(.POLY(CRC_POLY), .INIT(CRC_INIT), .REFLECT(REFLECT)) u_crc (
      .clk(clk), .rst_n(rst_n), .load(load), .msg(msg), .len(len),
      .crc(crc_out), .busy(busy), .last_bit(last_bit));

   crc4c_frame_build u_frame (
      .aw(aw_q), .cmd(cmd_q), .addr_m(addr_q), .data(data_q), .crc(crc_out),
      .frame(frame), .frame_len(frame_len));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done    <= 1'b0;
         error   <= 1'b0;
         refused <= 1'b0;
         aw_q    <= '0;
         cmd_q   <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
         rx_q    <= '0;
      end else if (accept) begin
         done    <= 1'b0;
         error   <= !kind.ok;
         refused <= kind.ok && prot;
         if (load) begin
            aw_q   <= kind.aw;
            cmd_q  <= cmd_rd;
            addr_q <= addr_m;
            data_q <= data;
            rx_q   <= rsp[CHK_LSB +: CRC_W];
         end
      end else if (last_bit) begin
         done <= 1'b1;
      end
   end

   assign match = done && (crc_out == rx_q);

   // R6
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !kind.ok) |=> (error && !done && !busy));
   // R7
   prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && kind.ok && prot) |=> (refused && !busy && !done));
   // R10
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, error, refused}));
   // R2
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));
   // R5
   match_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |-> done);
   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(rx_q) && $stable(addr_q) && $stable(data_q)));
endmodule

// File: tb/crc4c_checker_tb.sv
module crc4c_checker_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;
   localparam int NVEC       = 8;
   // {code, cmd_rd, addr, data, good}
   localparam logic [27:0] VEC [NVEC] = '{
      {8'h0D, 1'b1, 10'h003, 8'hA5, 1'b1},
      {8'h0D, 1'b0, 10'h007, 8'h3C, 1'b1},
      {8'h1D, 1'b1, 10'h0FF, 8'h00, 1'b0},
      {8'h1D, 1'b0, 10'h080, 8'hFF, 1'b1},
      {8'h3D, 1'b1, 10'h3FF, 8'h5A, 1'b1},
      {8'h3D, 1'b0, 10'h155, 8'h81, 1'b0},
      {8'h0D, 1'b1, 10'h3E5, 8'h11, 1'b1},
      {8'h3D, 1'b1, 10'h000, 8'h00, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  card_type = '0;
   logic        cmd_rd = 1'b0;
   logic [9:0]  addr = '0;
   logic [7:0]  data = '0;
   logic [11:0] rsp = '0;
   logic [3:0]  crc_out;
   logic        match, done, error, refused, busy;
   logic [22:0] frame;
   logic [4:0]  frame_len;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   crc4c_checker dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .card_type(card_type),
      .cmd_rd(cmd_rd), .addr(addr), .data(data), .rsp(rsp),
      .crc_out(crc_out), .match(match), .done(done), .error(error),
      .refused(refused), .busy(busy), .frame(frame), .frame_len(frame_len));

   function automatic int aw_of(input logic [7:0] c);
      if (c == 8'h0D) return 5;
      if (c == 8'h1D) return 8;
      if (c == 8'h3D) return 10;
      return 0;
   endfunction

   function automatic logic [3:0] ref_crc(input logic [31:0] m, input int n);
      logic [3:0] c = 4'h5;
      for (int i = 0; i < n; i++) begin
         logic fb = c[0] ^ m[i];
         c = c >> 1;
         if (fb) c = c ^ 4'hC;
      end
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic launch(input logic [7:0] c, input logic cr, input logic [9:0] a,
                         input logic [7:0] d, input logic [11:0] r);
      @(negedge clk);
      card_type = c; cmd_rd = cr; addr = a; data = d; rsp = r; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
   endtask

   // Runs one valid operation and checks latency, CRC, match and frame.
   task automatic run_valid(input logic [7:0] c, input logic cr, input logic [9:0] a,
                            input logic [7:0] d, input bit good, input int glitch);
      int aw = aw_of(c);
      int len = aw + 9;
      logic [9:0]  am = a & ((10'd1 << aw) - 10'd1);
      logic [31:0] m = (32'(d) << (aw + 1)) | (32'(am) << 1) | 32'(cr);
      logic [3:0]  e = ref_crc(m, len);
      logic [3:0]  rxn = good ? e : (e ^ 4'h3);
      logic [31:0] fr = (32'(e) << (aw + 9)) | m;
      launch(c, cr, a, d, {rxn, ~d});
      for (int i = 1; i < len; i++) begin
         @(posedge clk);
         if (i == glitch) begin
            // R9: a second strobe with other operands while busy
            @(negedge clk);
            start = 1'b1; addr = ~a; data = ~d; rsp = {~rxn, d};
            @(posedge clk);
            i++;
            @(negedge clk);
            start = 1'b0;
         end
      end
      @(negedge clk);
      chk(busy && !done, "R2 busy before last bit", {busy, done}, 2'b10);
      @(posedge clk);
      @(negedge clk);
      chk(done && !busy, "R2 done after message length", {done, busy}, 2'b10);
      chk(crc_out == e, "R4 crc value", crc_out, e);
      chk(match == good, "R5 match flag", match, good);
      chk(frame == fr[22:0], "R8 frame word", frame, fr[22:0]);
      chk(frame_len == 5'(aw + 13), "R8 frame length", frame_len, aw + 13);
      chk(!error && !refused, "R10 stale flags cleared", {error, refused}, 0);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk({done, match, error, refused, busy} == 5'b0, "R1 reset flags",
          {done, match, error, refused, busy}, 0);
      chk(crc_out == 4'h5, "R1 reset crc", crc_out, 4'h5);
      rst_n = 1'b1;

      // Vector table: R2, R3, R4, R5, R8
      for (int v = 0; v < NVEC; v++) begin
         run_valid(VEC[v][27:20], VEC[v][19], VEC[v][18:9], VEC[v][8:1], VEC[v][0], 0);
      end

      // R6 unknown code
      launch(8'h2D, 1'b1, 10'h010, 8'h77, 12'h000);
      chk(error && !done && !busy && !match, "R6 unknown code",
          {error, done, busy, match}, 4'b1000);
      repeat (25) @(posedge clk);
      @(negedge clk);
      chk(!done && !busy, "R6 no completion later", {done, busy}, 0);

      // R7 protected write boundary
      launch(8'h1D, 1'b0, 10'h004, 8'h12, 12'h000);
      chk(refused && !busy && !done && !error, "R7 write to address 4 refused",
          {refused, busy, done, error}, 4'b1000);
      // R7 upper bits masked before the protection test
      launch(8'h0D, 1'b0, 10'h3E2, 8'h12, 12'h000);
      chk(refused && !busy, "R7 masked address 2 refused", {refused, busy}, 2'b10);
      // R7 write to 5 and read of 0 run normally; R10 clears refused
      run_valid(8'h1D, 1'b0, 10'h005, 8'h9C, 1'b1, 0);
      run_valid(8'h0D, 1'b1, 10'h000, 8'h42, 1'b1, 0);

      // R9 start during busy ignored
      run_valid(8'h3D, 1'b1, 10'h2A7, 8'hC3, 1'b1, 4);
      run_valid(8'h0D, 1'b0, 10'h01F, 8'hE0, 1'b0, 6);

      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule